// File: doc/BRIEF.md
# Burst SRAM Cycle and Byte-Write Decoder

This block sits behind the input registers of a pipelined burst SRAM. On each rising clock edge it looks at the chip enable, the two chip selects, the two address-start strobes, the burst-advance input and the write controls. It decides what kind of cycle the edge starts and which byte lanes of the 32-bit word are written. Its results are held in registers for one clock, so that they line up with the registered write data that the array sees one cycle later.

One start strobe comes from the processor and is gated by chip enable. The other comes from the cache controller and is not gated. A processor-strobe start always begins a read. A controller-strobe start begins a read or a write, depending on the write controls. When no strobe is active, the burst carries on: it advances or it holds its position. The block remembers whether the device is currently selected, and an unstrobed cycle keeps that state. Chip enable and the chip selects only matter on a strobe cycle. Any cycle that writes also asks the output path to turn its drivers off.

Top module: `sram_cycle_decoder`

## Requirements
- R1: The device counts as selected on an edge only when `chip_en_n`=0, `sel_hi`=1 and `sel_lo_n`=0. A strobe cycle that fails any one of these three conditions does not start a burst.
- R2: These edges are deselect cycles: `chip_en_n`=1 with `start_ctl_n`=0, or `chip_en_n`=0 with a chip select inactive and either strobe low. One cycle later a deselect cycle gives `cyc_kind`=0, `lane_we`=0000 and `active`=0.
- R3: When the device is selected and `start_cpu_n`=0, `cyc_kind` becomes 1 (begin read) and `lane_we` becomes 0000, whatever the write inputs are. `active` becomes 1.
- R4: When the device is selected, `start_cpu_n`=1 and `start_ctl_n`=0, `cyc_kind` becomes 2 (begin write) if any lane is written, and 1 otherwise. `active` becomes 1.
- R5: On a cycle that is allowed to write, `wr_all_n`=0 gives `lane_we`=1111, whatever `wr_gate_n` and `lane_wr_n` are.
- R6: When `wr_gate_n`=1 and `wr_all_n`=1, `lane_we`=0000 for every value of `lane_wr_n`.
- R7: When `wr_gate_n`=0 and `wr_all_n`=1, `lane_we[i]` equals the inverse of `lane_wr_n[i]`. Lane i covers data bits 8i+7..8i. Any combination of lanes may be set in the same cycle.
- R8: An edge with no effective strobe (`start_ctl_n`=1, and either `start_cpu_n`=1 or `chip_en_n`=1) while `active`=1 is a burst step. With `step_n`=0 it gives `cyc_kind` 3 (read) or 4 (write). With `step_n`=1 it gives 5 (read) or 6 (write). The chip selects are ignored and `active` stays 1.
- R9: An edge with no effective strobe while `active`=0 gives `cyc_kind`=0 and `lane_we`=0000, and `active` stays 0.
- R10: `drv_off` is 1 exactly when `lane_we` is non-zero.
- R11: Every output reflects the inputs sampled at the previous edge. A synchronous reset (`rst_n`=0) gives `cyc_kind`=0, `lane_we`=0000, `active`=0 and `drv_off`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| chip_en_n | input | 1 | Chip enable, active low; gates the processor strobe |
| sel_hi | input | 1 | Chip select, active high |
| sel_lo_n | input | 1 | Chip select, active low |
| start_cpu_n | input | 1 | Processor address-start strobe, active low |
| start_ctl_n | input | 1 | Cache-controller address-start strobe, active low |
| step_n | input | 1 | Burst advance, active low |
| wr_all_n | input | 1 | Global write of all lanes, active low |
| wr_gate_n | input | 1 | Gate for the per-lane write selects, active low |
| lane_wr_n | input | 4 | Per-lane write selects, active low; bit i covers data bits 8i+7..8i |
| cyc_kind | output | 3 | Registered cycle type: 0 deselect/idle, 1 begin read, 2 begin write, 3 step read, 4 step write, 5 hold read, 6 hold write |
| lane_we | output | 4 | Registered per-lane write enable |
| active | output | 1 | Registered selected state |
| drv_off | output | 1 | Registered request to disable the data output drivers |

## Verification
On every cycle, assertions check the following:
- a deselect edge clears the selected state and blocks every write;
- a processor-strobe start never writes;
- a global write on a controller start sets every lane;
- a closed byte gate blocks the per-lane selects;
- an unstrobed cycle while deselected stays idle;
- the driver-off request always tracks the lane mask.

Some behaviour only the bench scenarios can show. This includes the mapping from each lane select to its own lane, and the split of unstrobed cycles into step and hold and into read and write. It also includes a selected state that is carried across long runs of unstrobed cycles, reset values, and start decisions that mix a failed chip select with each strobe.

// File: rtl/sram_cyc_pkg.sv
// Shared types for the burst SRAM cycle decoder.
// Assumes: a cycle-kind code of 7 is never produced.
package sram_cyc_pkg;

    // Registered cycle classification seen by the array and the counter
    typedef enum logic [2:0] {
        CK_IDLE     = 3'd0,
        CK_START_RD = 3'd1,
        CK_START_WR = 3'd2,
        CK_STEP_RD  = 3'd3,
        CK_STEP_WR  = 3'd4,
        CK_HOLD_RD  = 3'd5,
        CK_HOLD_WR  = 3'd6
    } cyc_kind_e;

    // What the strobes and selects mean on one edge
    typedef enum logic [1:0] {
        SC_NONE  = 2'd0,
        SC_DESEL = 2'd1,
        SC_CPU   = 2'd2,
        SC_CTL   = 2'd3
    } strobe_cls_e;

endpackage

// File: rtl/sram_strobe_class.sv
// Classifies one edge from chip enable, chip selects and the two start strobes.
// Assumes: the processor strobe counts only while chip enable is low,
// and it has priority over the controller strobe.
module sram_strobe_class
    import sram_cyc_pkg::*;
(
    input  logic        chip_en_n,
    input  logic        sel_hi,
    input  logic        sel_lo_n,
    input  logic        start_cpu_n,
    input  logic        start_ctl_n,
    output strobe_cls_e cls
);
    logic sel_ok;

    assign sel_ok = sel_hi && !sel_lo_n;

    // Pick the edge class. A deselect is recognised only on a strobe.
    always_comb begin
        if (chip_en_n) begin
            cls = start_ctl_n ? SC_NONE : SC_DESEL;
        end else if (!sel_ok) begin
            cls = (start_cpu_n && start_ctl_n) ? SC_NONE : SC_DESEL;
        end else if (!start_cpu_n) begin
            cls = SC_CPU;
        end else if (!start_ctl_n) begin
            cls = SC_CTL;
        end else begin
            cls = SC_NONE;
        end
    end
endmodule

// File: rtl/sram_lane_we.sv
// Builds the per-lane write mask from the global write, the byte gate and the lane selects.
// Assumes: 'block' is high on cycles that must not write, such as a processor
// start, a deselect, or an idle cycle.
module sram_lane_we #(
    parameter int NUM_LANES = 4
) (
    input  logic                 block,
    input  logic                 wr_all_n,
    input  logic                 wr_gate_n,
    input  logic [NUM_LANES-1:0] lane_wr_n,
    output logic [NUM_LANES-1:0] lane_we,
    output logic                 any_we
);
    // One enable per lane. The global write overrides the gated selects.
    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        always_comb begin
            lane_we[g] = !block && (!wr_all_n || (!wr_gate_n && !lane_wr_n[g]));
        end
    end

    // Reduce to a single "this cycle writes" flag
    assign any_we = |lane_we;
endmodule

// File: rtl/sram_cyc_state.sv
// Holds the selected state and registers the cycle kind, lane mask and driver-off request.
// Assumes: cls and the mask come from the same edge; the reset is synchronous and active low.
module sram_cyc_state
    import sram_cyc_pkg::*;
#(
    parameter int NUM_LANES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  strobe_cls_e          cls,
    input  logic                 step_n,
    input  logic [NUM_LANES-1:0] mask_d,
    input  logic                 any_we_d,
    output cyc_kind_e            kind_q,
    output logic [NUM_LANES-1:0] mask_q,
    output logic                 active_q,
    output logic                 drv_off_q
);
    cyc_kind_e kind_d;
    logic      active_d;

    // Next cycle kind and next selected state
    always_comb begin
        kind_d   = CK_IDLE;
        active_d = active_q;
        case (cls)
            SC_DESEL: begin
                kind_d   = CK_IDLE;
                active_d = 1'b0;
            end
            SC_CPU: begin
                kind_d   = CK_START_RD;
                active_d = 1'b1;
            end
            SC_CTL: begin
                kind_d   = any_we_d ? CK_START_WR : CK_START_RD;
                active_d = 1'b1;
            end
            default: begin
                if (!active_q) begin
                    kind_d = CK_IDLE;
                end else if (!step_n) begin
                    kind_d = any_we_d ? CK_STEP_WR : CK_STEP_RD;
                end else begin
                    kind_d = any_we_d ? CK_HOLD_WR : CK_HOLD_RD;
                end
            end
        endcase
    end

    // Output registers, aligned with the registered write data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q    <= CK_IDLE;
            mask_q    <= '0;
            active_q  <= 1'b0;
            drv_off_q <= 1'b0;
        end else begin
            kind_q    <= kind_d;
            mask_q    <= mask_d;
            active_q  <= active_d;
            drv_off_q <= any_we_d;
        end
    end

    // R11: the registered kind is never the unused code
    a_r11_kind_legal: assert property (@(posedge clk) disable iff (!rst_n)
        kind_q != cyc_kind_e'(3'd7));

    // R8: a burst-step kind only appears while the selected state holds
    a_r8_step_needs_active: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_q == CK_STEP_RD || kind_q == CK_STEP_WR ||
         kind_q == CK_HOLD_RD || kind_q == CK_HOLD_WR) |-> active_q);
endmodule

// File: rtl/sram_cycle_decoder.sv
// Top level: decodes each edge of a burst SRAM's control inputs into a registered
// cycle kind, a per-lane write mask, the selected state and a driver-off request.
// Assumes: the inputs are already synchronous to clk; the array and the address counter are outside.
module sram_cycle_decoder
    import sram_cyc_pkg::*;
#(
    parameter int NUM_LANES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 chip_en_n,
    input  logic                 sel_hi,
    input  logic                 sel_lo_n,
    input  logic                 start_cpu_n,
    input  logic                 start_ctl_n,
    input  logic                 step_n,
    input  logic                 wr_all_n,
    input  logic                 wr_gate_n,
    input  logic [NUM_LANES-1:0] lane_wr_n,
    output logic [2:0]           cyc_kind,
    output logic [NUM_LANES-1:0] lane_we,
    output logic                 active,
    output logic                 drv_off
);
    localparam logic [NUM_LANES-1:0] ALL_LANES = {NUM_LANES{1'b1}};

    strobe_cls_e          cls;
    logic                 wr_block;
    logic [NUM_LANES-1:0] mask_d;
    logic                 any_we_d;
    cyc_kind_e            kind_q;
    logic                 sel_now;

    sram_strobe_class u_cls (
        .chip_en_n   (chip_en_n),
        .sel_hi      (sel_hi),
        .sel_lo_n    (sel_lo_n),
        .start_cpu_n (start_cpu_n),
        .start_ctl_n (start_ctl_n),
        .cls         (cls)
    );

    // Writes are blocked on a processor start, a deselect, or an idle unstrobed cycle
    always_comb begin
        wr_block = (cls == SC_CPU) || (cls == SC_DESEL) || (cls == SC_NONE && !active);
    end

    sram_lane_we #(.NUM_LANES(NUM_LANES)) u_we (
        .block     (wr_block),
        .wr_all_n  (wr_all_n),
        .wr_gate_n (wr_gate_n),
        .lane_wr_n (lane_wr_n),
        .lane_we   (mask_d),
        .any_we    (any_we_d)
    );

    sram_cyc_state #(.NUM_LANES(NUM_LANES)) u_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .cls       (cls),
        .step_n    (step_n),
        .mask_d    (mask_d),
        .any_we_d  (any_we_d),
        .kind_q    (kind_q),
        .mask_q    (lane_we),
        .active_q  (active),
        .drv_off_q (drv_off)
    );

    assign cyc_kind = kind_q;

    // Port-level select qualification, used only by the checks below
    assign sel_now = !chip_en_n && sel_hi && !sel_lo_n;

    // R2: a deselect on the controller strobe clears the state and blocks writes
    a_r2_desel: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_en_n && !start_ctl_n) |=> (cyc_kind == 3'd0 && !active && lane_we == '0));

    // R3: a processor start while selected begins a read and never writes
    a_r3_cpu_read: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_now && !start_cpu_n) |=> (cyc_kind == 3'd1 && lane_we == '0 && active));

    // R5: a global write on a controller start writes every lane
    a_r5_all_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_now && start_cpu_n && !start_ctl_n && !wr_all_n)
        |=> (lane_we == ALL_LANES && cyc_kind == 3'd2));

    // R6: a closed byte gate without a global write blocks the lane selects
    a_r6_gate_closed: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_all_n && wr_gate_n) |=> (lane_we == '0));

    // R9: an unstrobed cycle while deselected stays idle
    a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && start_ctl_n && (start_cpu_n || chip_en_n))
        |=> (cyc_kind == 3'd0 && !active && lane_we == '0));

    // R10: the driver-off request follows the lane mask
    a_r10_drv_off: assert property (@(posedge clk) disable iff (!rst_n)
        drv_off == (lane_we != '0));
endmodule

// File: tb/sram_cycle_decoder_bench.sv
module sram_cycle_decoder_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       chip_en_n, sel_hi, sel_lo_n, start_cpu_n, start_ctl_n, step_n;
    logic       wr_all_n, wr_gate_n;
    logic [3:0] lane_wr_n;
    logic [2:0] cyc_kind;
    logic [3:0] lane_we;
    logic       active, drv_off;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  m_act    = 1'b0;
    bit  finished = 1'b0;

    always #5 clk = ~clk;

    sram_cycle_decoder u_sram_cycle_decoder (
        .clk(clk), .rst_n(rst_n), .chip_en_n(chip_en_n), .sel_hi(sel_hi),
        .sel_lo_n(sel_lo_n), .start_cpu_n(start_cpu_n), .start_ctl_n(start_ctl_n),
        .step_n(step_n), .wr_all_n(wr_all_n), .wr_gate_n(wr_gate_n),
        .lane_wr_n(lane_wr_n), .cyc_kind(cyc_kind), .lane_we(lane_we),
        .active(active), .drv_off(drv_off)
    );

    // Expected {next active, mask, kind} from the requirements
    function automatic logic [7:0] model(input bit act, input logic ce, hi, lo, cpu, ctl,
                                         step, gw, gate, input logic [3:0] ln);
        logic       sel;
        logic [3:0] wm;
        logic [2:0] k;
        sel = !ce && hi && !lo;
        wm  = !gw ? 4'hF : (!gate ? ~ln : 4'h0);
        if ((ce && !ctl) || (!ce && !(hi && !lo) && (!cpu || !ctl))) return 8'h00;
        if (sel && !cpu) return {1'b1, 4'h0, 3'd1};
        if (sel && !ctl) return {1'b1, wm, (wm != 0) ? 3'd2 : 3'd1};
        if (!act) return 8'h00;
        if (!step) k = (wm != 0) ? 3'd4 : 3'd3;
        else       k = (wm != 0) ? 3'd6 : 3'd5;
        return {1'b1, wm, k};
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive one edge, then compare all outputs against the model
    task automatic run(input string tag, input logic ce, hi, lo, cpu, ctl, step, gw, gate,
                       input logic [3:0] ln);
        logic [7:0] e;
        chip_en_n = ce; sel_hi = hi; sel_lo_n = lo; start_cpu_n = cpu; start_ctl_n = ctl;
        step_n = step; wr_all_n = gw; wr_gate_n = gate; lane_wr_n = ln;
        e = model(m_act, ce, hi, lo, cpu, ctl, step, gw, gate, ln);
        @(posedge clk);
        @(negedge clk);
        m_act = e[7];
        chk(tag, cyc_kind, e[2:0]);
        chk(tag, lane_we, e[6:3]);
        chk(tag, active, e[7]);
        chk("R10", drv_off, (e[6:3] != 0));
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst_n = 1'b0;
        chip_en_n = 0; sel_hi = 1; sel_lo_n = 0; start_cpu_n = 0; start_ctl_n = 0;
        step_n = 0; wr_all_n = 0; wr_gate_n = 0; lane_wr_n = 4'h0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11: reset values
        chk("R11", cyc_kind, 0); chk("R11", lane_we, 0);
        chk("R11", active, 0);   chk("R11", drv_off, 0);
        rst_n = 1'b1;

        // R1: a failed chip select on a strobe does not start a burst
        run("R1", 0, 0, 0, 1, 0, 1, 0, 1, 4'hF);
        chk("R1", active, 0);
        run("R1", 0, 1, 1, 0, 1, 1, 1, 1, 4'hF);
        chk("R1", active, 0);
        // R9: idle while deselected, even with a global write
        run("R9", 1, 0, 1, 1, 1, 0, 0, 0, 4'h0);
        chk("R9", lane_we, 0);
        // R3: a processor start with every write asserted is still a read
        run("R3", 0, 1, 0, 0, 0, 0, 0, 0, 4'h0);
        chk("R3", cyc_kind, 1); chk("R3", lane_we, 0);
        // R8: step read, hold write via lanes, chip selects ignored
        run("R8", 0, 0, 1, 1, 1, 0, 1, 1, 4'h0);
        chk("R8", cyc_kind, 3);
        run("R8", 1, 0, 1, 0, 1, 1, 1, 0, 4'h6);
        chk("R8", cyc_kind, 6); chk("R7", lane_we, 4'h9);
        // R2: controller strobe with chip enable high deselects
        run("R2", 1, 1, 0, 1, 0, 0, 0, 0, 4'h0);
        chk("R2", active, 0); chk("R2", cyc_kind, 0);
        // R5: global write overrides a closed gate
        run("R5", 0, 1, 0, 1, 0, 0, 0, 1, 4'hF);
        chk("R5", lane_we, 4'hF); chk("R4", cyc_kind, 2);
        // R6: closed gate ignores the lane selects
        run("R6", 0, 1, 0, 1, 0, 0, 1, 1, 4'h0);
        chk("R6", lane_we, 0); chk("R4", cyc_kind, 1);
        // R7: each single lane, then a pair
        for (int i = 0; i < 4; i++) begin
            run("R7", 0, 1, 0, 1, 0, 0, 1, 0, ~(4'h1 << i));
            chk("R7", lane_we, 4'h1 << i);
        end
        run("R7", 1, 1, 1, 1, 1, 1, 1, 0, 4'h5);
        chk("R7", lane_we, 4'hA); chk("R8", cyc_kind, 6);
        // R8: a hold read
        run("R8", 0, 1, 0, 1, 1, 1, 1, 1, 4'h0);
        chk("R8", cyc_kind, 5);

        // Constrained random mix
        for (int n = 0; n < 3000; n++) begin
            logic ce, hi, lo, cpu, ctl;
            string tag;
            ce  = ($urandom % 5) == 0;
            hi  = ($urandom % 8) != 0;
            lo  = ($urandom % 8) == 0;
            cpu = ($urandom % 4) != 0;
            ctl = ($urandom % 4) != 0;
            if (ctl && (cpu || ce)) tag = m_act ? "R8" : "R9";
            else if ((ce && !ctl) || (!ce && !(hi && !lo))) tag = "R2";
            else if (!cpu) tag = "R3";
            else tag = "R4";
            run(tag, ce, hi, lo, cpu, ctl, $urandom % 2, ($urandom % 4) != 0,
                $urandom % 2, 4'($urandom));
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule